// File: doc/BRIEF.md
# Five-Level Cell PWM Gate Modulator

This block drives the five gate signals of one bridge cell that can put +Vdc, +Vdc/2, 0, -Vdc/2 or -Vdc on its output. Three of the gates (`gate_a`, `gate_b`, `gate_c`) toggle at carrier rate. The other two (`gate_pos`, `gate_neg`) select the half cycle and change only when the reference changes sign. The block contains its own symmetric up/down carrier counter. It takes a signed reference sample and scales it by a modulation index. It then folds the magnitude into a lower band (0 to one carrier peak) or an upper band (one to two carrier peaks, reduced by one peak). The band value is compared against the carrier.

The reference is given in carrier counts at unity index, so full scale is plus or minus twice the carrier peak. The modulation index is unsigned with 8 fraction bits, so 256 means 1.0. Band, sign and band level are captured only when the carrier is at its valley or its peak. When the gate selection in a group changes, the group stays fully off for a programmable number of cycles. Several cells can be cascaded by running one instance per cell.

Top module: `fivelvl_cell_pwm`

## Requirements
- R1: `carrier` counts up by one from 0 to `car_peak`, then down by one back to 0, so one period is 2*`car_peak` cycles. Each cycle it moves by exactly one count.
- R2: While `rst` is high, and on the first clock after it falls (the first carrier valley), all five gates are low. With `dead_cyc` = 0 the gates follow on the clock after that.
- R3: The working magnitude is floor(|`ref_in`| * `mod_idx` / 256), saturated to 2*`car_peak`.
- R4: The lower band holds magnitudes from 0 to `car_peak`, both ends included, and its level is the magnitude. The upper band holds larger magnitudes, and its level is the magnitude minus `car_peak`. The positive side is taken only when `ref_in` > 0 and the magnitude is non-zero. Otherwise the negative side is taken.
- R5: Positive side, lower band: `gate_pos` is on, and `gate_a` is on when the band is active, otherwise `gate_c` (output +Vdc/2 or 0).
- R6: Positive side, upper band: `gate_pos` is on, and `gate_b` is on when the band is active, otherwise `gate_a` (output +Vdc or +Vdc/2).
- R7: Negative side, lower band: `gate_neg` is on, and `gate_a` is on when the band is active, otherwise `gate_b` (output -Vdc/2 or 0).
- R8: Negative side, upper band: `gate_neg` is on, and `gate_c` is on when the band is active, otherwise `gate_a` (output -Vdc or -Vdc/2).
- R9: The band is active in a cycle when the captured band level is greater than the carrier. Over one period, a level L is therefore active for 0 cycles if L = 0, and for 2L-1 cycles otherwise.
- R10: Sign, band and level are captured only in cycles where the carrier is 0 or equal to `car_peak`. A change of `ref_in` between those points has no effect on the gates until the next turning point.
- R11: Whenever the selected gate of a group changes (the toggling group {a,b,c} or the hold group {pos,neg}), every gate of that group is low for exactly `dead_cyc` cycles before the new gate turns on.
- R12: At most one of `gate_a`, `gate_b`, `gate_c` is high at any time, and `gate_pos` and `gate_neg` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | REF_W | Signed reference sample in carrier counts at unity index |
| mod_idx | input | MI_W | Modulation index, unsigned, 256 = 1.0 |
| car_peak | input | CAR_W | Carrier peak count (at least 1) |
| dead_cyc | input | DT_W | Dead time in clock cycles |
| carrier | output | CAR_W | Current carrier count |
| gate_a | output | 1 | Shared toggling switch |
| gate_b | output | 1 | Toggling switch, full positive level or negative zero |
| gate_c | output | 1 | Toggling switch, positive zero or full negative level |
| gate_neg | output | 1 | Negative half-cycle hold switch |
| gate_pos | output | 1 | Positive half-cycle hold switch |

## Verification
The bench sweeps the reference through every count from beyond negative full scale to beyond positive full scale. It does this at unity and at half index, and counts per-gate on-cycles over a whole carrier period. The sweep lands on the values 0 and ±`car_peak`. A design that placed these band edges on the wrong side would show a wrong gate or a duty that is off by a full band. Magnitudes past full scale catch a missing saturation, which would show up as a wrapped or overlarge upper level. A mid-ramp step of the reference checks that nothing moves before the peak, because a capture on every cycle would bring in the upper-band gate early. A dead-time run measures the all-off cycles per period and the shortened on-times, which exposes an off-by-one in the dead-time counter.

// File: rtl/fivelvl_cell_pwm.sv
module fivelvl_cell_pwm #(
  parameter int REF_W   = 12,
  parameter int MI_W    = 10,
  parameter int MI_FRAC = 8,
  parameter int CAR_W   = 10,
  parameter int DT_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic        [MI_W-1:0]  mod_idx,
  input  logic        [CAR_W-1:0] car_peak,
  input  logic        [DT_W-1:0]  dead_cyc,
  output logic        [CAR_W-1:0] carrier,
  output logic                    gate_a,
  output logic                    gate_b,
  output logic                    gate_c,
  output logic                    gate_neg,
  output logic                    gate_pos
);
  localparam int PROD_W = REF_W + MI_W;
  localparam int MAG_W  = PROD_W - MI_FRAC;
  localparam int LVL_W  = CAR_W + 1;

  logic [CAR_W-1:0]  car;
  logic              car_up;
  logic [REF_W-1:0]  ref_abs;
  logic [PROD_W-1:0] prod;
  logic [MAG_W-1:0]  scaled;
  logic [LVL_W-1:0]  full_lvl, mag, band_lvl, lvl_q;
  logic              pos_n, upper_n, at_turn, pwm;
  logic              run, pos_q, upper_q;
  logic [2:0]        want_t, gq_t, prev_t;
  logic [1:0]        want_h, gq_h, prev_h;
  logic [DT_W-1:0]   cnt_t, cnt_h, dt_load;

  assign ref_abs  = ref_in[REF_W-1] ? REF_W'(-ref_in) : REF_W'(ref_in);
  assign prod     = PROD_W'(ref_abs) * PROD_W'(mod_idx);
  assign scaled   = MAG_W'(prod >> MI_FRAC);
  assign full_lvl = {car_peak, 1'b0};
  assign mag      = (scaled > MAG_W'(full_lvl)) ? full_lvl : LVL_W'(scaled);
  assign pos_n    = !ref_in[REF_W-1] && (mag != '0);
  assign upper_n  = mag > LVL_W'(car_peak);
  assign band_lvl = upper_n ? mag - LVL_W'(car_peak) : mag;
  assign at_turn  = (car == '0) || (car >= car_peak);
  assign pwm      = lvl_q > LVL_W'(car);
  assign dt_load  = (dead_cyc == '0) ? '0 : dead_cyc - DT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      car    <= '0;
      car_up <= 1'b1;
    end else if (car_up) begin
      if (car >= car_peak) begin
        car_up <= 1'b0;
        car    <= car - CAR_W'(1);
      end else begin
        car <= car + CAR_W'(1);
      end
    end else if (car == '0) begin
      car_up <= 1'b1;
      car    <= car + CAR_W'(1);
    end else begin
      car <= car - CAR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      pos_q   <= 1'b0;
      upper_q <= 1'b0;
      lvl_q   <= '0;
    end else if (at_turn) begin
      run     <= 1'b1;
      pos_q   <= pos_n;
      upper_q <= upper_n;
      lvl_q   <= band_lvl;
    end
  end

  // want_t bit order: {c, b, a}
  always_comb begin
    unique case ({pos_q, upper_q})
      2'b10:   want_t = pwm ? 3'b001 : 3'b100;
      2'b11:   want_t = pwm ? 3'b010 : 3'b001;
      2'b00:   want_t = pwm ? 3'b001 : 3'b010;
      default: want_t = pwm ? 3'b100 : 3'b001;
    endcase
    if (!run) want_t = 3'b000;
  end

  assign want_h = !run ? 2'b00 : (pos_q ? 2'b10 : 2'b01);

  always_ff @(posedge clk) begin
    if (rst) begin
      gq_t   <= '0;
      prev_t <= '0;
      cnt_t  <= '0;
    end else if (want_t != prev_t) begin
      prev_t <= want_t;
      cnt_t  <= dt_load;
      gq_t   <= (dead_cyc == '0) ? want_t : 3'b000;
    end else if (cnt_t != '0) begin
      cnt_t <= cnt_t - DT_W'(1);
    end else begin
      gq_t <= want_t;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gq_h   <= '0;
      prev_h <= '0;
      cnt_h  <= '0;
    end else if (want_h != prev_h) begin
      prev_h <= want_h;
      cnt_h  <= dt_load;
      gq_h   <= (dead_cyc == '0) ? want_h : 2'b00;
    end else if (cnt_h != '0) begin
      cnt_h <= cnt_h - DT_W'(1);
    end else begin
      gq_h <= want_h;
    end
  end

  assign carrier  = car;
  assign gate_a   = gq_t[0];
  assign gate_b   = gq_t[1];
  assign gate_c   = gq_t[2];
  assign gate_neg = gq_h[0];
  assign gate_pos = gq_h[1];
endmodule

// File: rtl/fivelvl_cell_pwm_chk.sv
module fivelvl_cell_pwm_chk #(
  parameter int CAR_W = 10,
  parameter int DT_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [CAR_W-1:0] car_peak,
  input logic [DT_W-1:0]  dead_cyc,
  input logic [CAR_W-1:0] carrier,
  input logic             gate_a,
  input logic             gate_b,
  input logic             gate_c,
  input logic             gate_neg,
  input logic             gate_pos
);
  a_r12_no_short: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gate_a, gate_b, gate_c}) && !(gate_pos && gate_neg));

  a_r2_low_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ({gate_a, gate_b, gate_c, gate_neg, gate_pos} == 5'b0));

  a_r1_unit_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (carrier == $past(carrier) + CAR_W'(1) ||
                     carrier == $past(carrier) - CAR_W'(1)));

  a_r1_in_range: assert property (@(posedge clk) disable iff (rst)
    carrier <= car_peak);

  a_r11_dead_toggle: assert property (@(posedge clk) disable iff (rst)
    (dead_cyc != '0 && ($rose(gate_a) || $rose(gate_b) || $rose(gate_c)))
      |-> ($past({gate_a, gate_b, gate_c}) == 3'b000));

  a_r11_dead_hold: assert property (@(posedge clk) disable iff (rst)
    (dead_cyc != '0 && ($rose(gate_pos) || $rose(gate_neg)))
      |-> ($past({gate_pos, gate_neg}) == 2'b00));
endmodule

bind fivelvl_cell_pwm fivelvl_cell_pwm_chk #(.CAR_W(CAR_W), .DT_W(DT_W)) u_chk (
  .clk(clk), .rst(rst), .car_peak(car_peak), .dead_cyc(dead_cyc),
  .carrier(carrier), .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c),
  .gate_neg(gate_neg), .gate_pos(gate_pos)
);

// File: tb/fivelvl_cell_pwm_tb.sv
module fivelvl_cell_pwm_tb;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic signed [11:0] ref_in = '0;
  logic [9:0]        mod_idx = 10'd256;
  logic [9:0]        car_peak = 10'd4;
  logic [3:0]        dead_cyc = '0;
  logic [9:0]        carrier;
  logic              gate_a, gate_b, gate_c, gate_neg, gate_pos;

  int total = 0;
  int bad = 0;
  int overlaps = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  fivelvl_cell_pwm u_dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .mod_idx(mod_idx),
    .car_peak(car_peak), .dead_cyc(dead_cyc), .carrier(carrier),
    .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c),
    .gate_neg(gate_neg), .gate_pos(gate_pos)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // R12: sample-level overlap monitor
  always @(negedge clk) begin
    if (!rst && (int'(gate_a) + int'(gate_b) + int'(gate_c) > 1 || (gate_pos && gate_neg)))
      overlaps++;
  end

  task automatic do_reset(input int p, input int dt);
    @(negedge clk);
    rst = 1'b1;
    car_peak = 10'(p);
    dead_cyc = 4'(dt);
    repeat (3) @(negedge clk);
    chk({gate_a, gate_b, gate_c, gate_neg, gate_pos} == 5'b0, "R2 gates in reset",
        int'({gate_a, gate_b, gate_c, gate_neg, gate_pos}), 0);
    rst = 1'b0;
  endtask

  task automatic measure(input int v, input int m, input int p);
    int mag, r, hi, lo, ea, eb, ec, ep, en;
    int ca, cb, cc, cp, cn;
    bit pos, up;
    string tag;
    ref_in = 12'(v);
    mod_idx = 10'(m);
    do @(negedge clk); while (carrier != 0);
    repeat (2 * p) @(negedge clk);
    ca = 0; cb = 0; cc = 0; cp = 0; cn = 0;
    for (int i = 0; i < 2 * p; i++) begin
      @(negedge clk);
      ca += int'(gate_a); cb += int'(gate_b); cc += int'(gate_c);
      cp += int'(gate_pos); cn += int'(gate_neg);
    end
    mag = ((v < 0 ? -v : v) * m) >>> 8;
    if (mag > 2 * p) mag = 2 * p;
    pos = (v > 0) && (mag > 0);
    up = mag > p;
    r = up ? mag - p : mag;
    hi = (r == 0) ? 0 : 2 * r - 1;
    lo = 2 * p - hi;
    ea = 0; eb = 0; ec = 0;
    if (pos && !up) begin ea = hi; ec = lo; tag = "R5 R9"; end
    else if (pos && up) begin eb = hi; ea = lo; tag = "R6 R9"; end
    else if (!pos && !up) begin ea = hi; eb = lo; tag = "R7 R9"; end
    else begin ec = hi; ea = lo; tag = "R8 R9"; end
    ep = pos ? 2 * p : 0;
    en = pos ? 0 : 2 * p;
    if (mag == 0 || mag == p) tag = {tag, " R4"};
    if (m != 256 || mag == 2 * p) tag = {tag, " R3"};
    chk(ca == ea, $sformatf("%s v=%0d m=%0d gate_a", tag, v, m), ca, ea);
    chk(cb == eb, $sformatf("%s v=%0d m=%0d gate_b", tag, v, m), cb, eb);
    chk(cc == ec, $sformatf("%s v=%0d m=%0d gate_c", tag, v, m), cc, ec);
    chk(cp == ep, $sformatf("%s v=%0d m=%0d gate_pos", tag, v, m), cp, ep);
    chk(cn == en, $sformatf("%s v=%0d m=%0d gate_neg", tag, v, m), cn, en);
  endtask

  initial begin
    int prev, steps_bad, mx, z0, z1, viol, zeros, ca, cc, off;
    // R2 / R1 start-up, P=4, dead 0
    ref_in = 12'sd4;
    do_reset(4, 0);
    @(negedge clk);
    chk({gate_a, gate_b, gate_c, gate_neg, gate_pos} == 5'b0, "R2 gates at first valley",
        int'({gate_a, gate_b, gate_c, gate_neg, gate_pos}), 0);
    chk(carrier == 10'd1, "R1 carrier after first valley", int'(carrier), 1);
    @(negedge clk);
    chk(gate_pos && gate_a, "R2 R5 gates follow one cycle later",
        int'({gate_a, gate_pos}), 3);

    // R1 carrier shape
    prev = int'(carrier); steps_bad = 0; mx = 0; z0 = -1; z1 = -1; zeros = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (int'(carrier) - prev != 1 && prev - int'(carrier) != 1) steps_bad++;
      prev = int'(carrier);
      if (int'(carrier) > mx) mx = int'(carrier);
      if (carrier == 0) begin
        if (zeros == 0) z0 = i; else if (zeros == 1) z1 = i;
        zeros++;
      end
    end
    chk(steps_bad == 0, "R1 unit steps", steps_bad, 0);
    chk(mx == 4, "R1 peak", mx, 4);
    chk(z1 - z0 == 8, "R1 period", z1 - z0, 8);

    // Sweep at unity index and half index
    for (int v = -11; v <= 11; v++) measure(v, 256, 4);
    for (int v = -19; v <= 19; v += 3) measure(v, 128, 4);

    // R11 dead time, P=8, dead 3, lower positive band level 5
    ref_in = 12'sd5;
    mod_idx = 10'd256;
    do_reset(8, 3);
    viol = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if ({gate_a, gate_b, gate_c, gate_neg, gate_pos} != 5'b0) viol++;
    end
    chk(viol == 0, "R2 R11 startup held low", viol, 0);
    @(negedge clk);
    chk(gate_pos == 1'b1, "R11 hold gate after dead time", int'(gate_pos), 1);
    do @(negedge clk); while (carrier != 0);
    repeat (16) @(negedge clk);
    ca = 0; cc = 0; off = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ca += int'(gate_a); cc += int'(gate_c);
      if (!gate_a && !gate_b && !gate_c) off++;
    end
    chk(off == 6, "R11 all-off cycles per period", off, 6);
    chk(ca == 6, "R11 gate_a shortened", ca, 6);
    chk(cc == 4, "R11 gate_c shortened", cc, 4);

    // R10 capture only at turning points, P=8, dead 0
    ref_in = 12'sd8;
    do_reset(8, 0);
    do @(negedge clk); while (carrier != 0);
    repeat (16) @(negedge clk);
    prev = int'(carrier);
    forever begin
      @(negedge clk);
      if (carrier == 10'd2 && prev == 1) break;
      prev = int'(carrier);
    end
    ref_in = 12'sd16;
    viol = 0;
    forever begin
      @(negedge clk);
      if (gate_b) viol++;
      if (carrier == 10'd8) break;
    end
    chk(viol == 0, "R10 no early band change", viol, 0);
    @(negedge clk);
    @(negedge clk);
    chk(gate_b == 1'b1 && gate_pos == 1'b1, "R10 R6 band change after peak",
        int'({gate_b, gate_pos}), 3);

    chk(overlaps == 0, "R12 overlapping gates", overlaps, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule